// File: doc/BRIEF.md
# Operand Bypass Selector for a Five-Stage Integer Pipeline

This block decides, every cycle, where the execute stage and the memory stage of an in-order five-stage pipeline take their operands from. It compares the source register numbers of the instruction now in execute with the destination registers held in the two pipeline registers downstream of it. From that comparison it produces select codes for the two ALU operand multiplexers: register file, the result waiting after execute, or the value waiting before write-back.

A third path covers a memory copy: a load followed at once by a store of the loaded register. The store, now in the memory stage, takes its write data straight from the load's returned value. No stall is needed. When both downstream stages write the register being read, the younger producer, the one just past execute, wins. A producer that targets register zero is never used, nor is one whose write enable is low. A load sitting just past execute holds an address rather than data, so it is never a bypass source. The stall logic that handles that case, the register file and the multiplexers themselves lie outside this block. It is purely combinational.

Top module: `fwd_unit`

## Requirements
- R1: With no producer matching any source, both ALU selects are 2'b00 (register file) and the store select is 0; an ALU select never takes the value 2'b11.
- R2: An ALU operand select is 2'b10 (value after execute) when the execute-to-memory producer has write enable high, a nonzero destination equal to that operand's source register, and is not a load.
- R3: An ALU operand select is 2'b01 (value before write-back) when the memory-to-write-back producer has write enable high and a nonzero destination equal to that operand's source, and R2 does not apply.
- R4: When both producers match an operand's source, the select is 2'b10 (younger producer).
- R5: A source or destination of register 0 never produces a nonzero select.
- R6: A producer with write enable low is never selected.
- R7: The two ALU operands are decided independently; an instruction reading the same register twice gets the same select on both.
- R8: The store select is 1 when the memory stage holds a store, the write-back producer is a load with write enable high, and its nonzero destination equals the store's data register.
- R9: The store select is 0 when the write-back producer is not a load, or when the memory stage holds no store.
- R10: A load held after execute is never selected for an ALU operand (select is not 2'b10 because of it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1 | input | REG_AW | First source register of the instruction in execute |
| ex_rs2 | input | REG_AW | Second source register of the instruction in execute |
| mem_st_rs | input | REG_AW | Data register of the instruction in the memory stage |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| xm_rd | input | REG_AW | Destination held in the execute-to-memory register |
| xm_we | input | 1 | Register write enable held after execute |
| xm_is_load | input | 1 | Instruction held after execute is a load |
| mw_rd | input | REG_AW | Destination held in the memory-to-write-back register |
| mw_we | input | 1 | Register write enable held before write-back |
| mw_is_load | input | 1 | Instruction held before write-back is a load |
| sel_a | output | 2 | First ALU operand select (00 file, 10 after execute, 01 before write-back) |
| sel_b | output | 2 | Second ALU operand select, same encoding |
| sel_st | output | 1 | Store data select (0 carried value, 1 loaded value) |

## Verification
The bench builds the block with its default register address width of 5, so registers 0 through 31 are reachable. That range covers register zero and its lack of a bypass, high numbers such as 31 that exercise every comparator bit, and the three-deep chain on one register that sets the two producers against each other. Each scenario drives one pipeline snapshot and compares all three selects against values written down from the requirements.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        OPSEL_FILE  = 2'b00,
        OPSEL_WBACK = 2'b01,
        OPSEL_EXEC  = 2'b10
    } opsel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] dst,
    input  logic              we,
    input  logic              usable,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic hit_d;

    always_comb begin
        hit_d = 1'b0;
        if (we && usable && (dst != ZERO_REG) && (dst == src)) begin
            hit_d = 1'b1;
        end
    end

    assign hit = hit_d;
endmodule

// File: rtl/fwd_opnd_sel.sv
module fwd_opnd_sel
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] xm_rd,
    input  logic              xm_we,
    input  logic              xm_is_load,
    input  logic [REG_AW-1:0] mw_rd,
    input  logic              mw_we,
    output opsel_e            sel
);
    logic xm_hit;
    logic mw_hit;
    opsel_e sel_d;

    fwd_match #(.REG_AW(REG_AW)) u_xm (
        .src    (src),
        .dst    (xm_rd),
        .we     (xm_we),
        .usable (!xm_is_load),
        .hit    (xm_hit)
    );

    fwd_match #(.REG_AW(REG_AW)) u_mw (
        .src    (src),
        .dst    (mw_rd),
        .we     (mw_we),
        .usable (1'b1),
        .hit    (mw_hit)
    );

    always_comb begin
        sel_d = OPSEL_FILE;
        if (xm_hit) begin
            sel_d = OPSEL_EXEC;
        end else if (mw_hit) begin
            sel_d = OPSEL_WBACK;
        end
    end

    assign sel = sel_d;
endmodule

// File: rtl/fwd_store_sel.sv
module fwd_store_sel #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] st_rs,
    input  logic              is_store,
    input  logic [REG_AW-1:0] mw_rd,
    input  logic              mw_we,
    input  logic              mw_is_load,
    output logic              sel
);
    logic mw_hit;

    fwd_match #(.REG_AW(REG_AW)) u_mw (
        .src    (st_rs),
        .dst    (mw_rd),
        .we     (mw_we),
        .usable (mw_is_load && is_store),
        .hit    (mw_hit)
    );

    assign sel = mw_hit;
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] ex_rs1,
    input  logic [REG_AW-1:0] ex_rs2,
    input  logic [REG_AW-1:0] mem_st_rs,
    input  logic              mem_is_store,
    input  logic [REG_AW-1:0] xm_rd,
    input  logic              xm_we,
    input  logic              xm_is_load,
    input  logic [REG_AW-1:0] mw_rd,
    input  logic              mw_we,
    input  logic              mw_is_load,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic              sel_st
);
    localparam int NUM_OPND = 2;

    logic [REG_AW-1:0] opnd_src [NUM_OPND];
    opsel_e            opnd_sel [NUM_OPND];

    assign opnd_src[0] = ex_rs1;
    assign opnd_src[1] = ex_rs2;

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        fwd_opnd_sel #(.REG_AW(REG_AW)) u_sel (
            .src        (opnd_src[g]),
            .xm_rd      (xm_rd),
            .xm_we      (xm_we),
            .xm_is_load (xm_is_load),
            .mw_rd      (mw_rd),
            .mw_we      (mw_we),
            .sel        (opnd_sel[g])
        );
    end

    fwd_store_sel #(.REG_AW(REG_AW)) u_st (
        .st_rs      (mem_st_rs),
        .is_store   (mem_is_store),
        .mw_rd      (mw_rd),
        .mw_we      (mw_we),
        .mw_is_load (mw_is_load),
        .sel        (sel_st)
    );

    assign sel_a = opnd_sel[0];
    assign sel_b = opnd_sel[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int REG_AW = 5
) (
    input logic [REG_AW-1:0] ex_rs1,
    input logic [REG_AW-1:0] ex_rs2,
    input logic [REG_AW-1:0] mem_st_rs,
    input logic              mem_is_store,
    input logic [REG_AW-1:0] xm_rd,
    input logic              xm_we,
    input logic              xm_is_load,
    input logic [REG_AW-1:0] mw_rd,
    input logic              mw_we,
    input logic              mw_is_load,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic              sel_st
);
    always_comb begin
        AST_A_LEGAL: assert (sel_a != 2'b11); // R1
        AST_B_LEGAL: assert (sel_b != 2'b11); // R1
        AST_A_EXEC_SRC: assert (sel_a != 2'b10 || (xm_we && xm_rd == ex_rs1 && xm_rd != '0)); // R2
        AST_A_WBACK_SRC: assert (sel_a != 2'b01 || (mw_we && mw_rd == ex_rs1 && mw_rd != '0)); // R3
        AST_B_WBACK_SRC: assert (sel_b != 2'b01 || (mw_we && mw_rd == ex_rs2 && mw_rd != '0)); // R3
        AST_A_YOUNGER: assert (!(xm_we && !xm_is_load && xm_rd == ex_rs1 && xm_rd != '0) || sel_a == 2'b10); // R4
        AST_ZERO_SRC: assert (ex_rs1 != '0 || sel_a == 2'b00); // R5
        AST_NO_WE: assert (xm_we || mw_we || (sel_a == 2'b00 && sel_b == 2'b00 && !sel_st)); // R6
        AST_SAME_REG: assert (ex_rs1 != ex_rs2 || sel_a == sel_b); // R7
        AST_ST_SRC: assert (!sel_st || (mem_is_store && mw_we && mw_rd == mem_st_rs && mw_rd != '0)); // R8
        AST_ST_LOAD_ONLY: assert (!sel_st || mw_is_load); // R9
        AST_NO_LOAD_EXEC: assert (!xm_is_load || (sel_a != 2'b10 && sel_b != 2'b10)); // R10
    end
endmodule

bind fwd_unit fwd_unit_chk #(.REG_AW(REG_AW)) u_fwd_unit_chk (
    .ex_rs1       (ex_rs1),
    .ex_rs2       (ex_rs2),
    .mem_st_rs    (mem_st_rs),
    .mem_is_store (mem_is_store),
    .xm_rd        (xm_rd),
    .xm_we        (xm_we),
    .xm_is_load   (xm_is_load),
    .mw_rd        (mw_rd),
    .mw_we        (mw_we),
    .mw_is_load   (mw_is_load),
    .sel_a        (sel_a),
    .sel_b        (sel_b),
    .sel_st       (sel_st)
);

// File: tb/test_fwd_unit.sv
`timescale 1ns/1ps
module test_fwd_unit;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0] ex_rs1, ex_rs2, mem_st_rs, xm_rd, mw_rd;
    logic mem_is_store, xm_we, xm_is_load, mw_we, mw_is_load;
    logic [1:0] sel_a, sel_b;
    logic sel_st;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    fwd_unit #(.REG_AW(AW)) i_fwd_unit (
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .mem_st_rs(mem_st_rs),
        .mem_is_store(mem_is_store), .xm_rd(xm_rd), .xm_we(xm_we),
        .xm_is_load(xm_is_load), .mw_rd(mw_rd), .mw_we(mw_we),
        .mw_is_load(mw_is_load), .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st)
    );

    task automatic clear_all();
        ex_rs1 = '0; ex_rs2 = '0; mem_st_rs = '0; mem_is_store = 1'b0;
        xm_rd = '0; xm_we = 1'b0; xm_is_load = 1'b0;
        mw_rd = '0; mw_we = 1'b0; mw_is_load = 1'b0;
    endtask

    task automatic apply(input logic [AW-1:0] rs1, input logic [AW-1:0] rs2,
                         input logic [AW-1:0] xrd, input logic xwe, input logic xld,
                         input logic [AW-1:0] mrd, input logic mwe, input logic mld,
                         input logic [AW-1:0] srs, input logic sst);
        @(negedge clk);
        ex_rs1 = rs1; ex_rs2 = rs2; xm_rd = xrd; xm_we = xwe; xm_is_load = xld;
        mw_rd = mrd; mw_we = mwe; mw_is_load = mld; mem_st_rs = srs; mem_is_store = sst;
        #1;
    endtask

    task automatic expect3(input string req, input logic [1:0] ea,
                           input logic [1:0] eb, input logic es);
        n_chk++;
        if (sel_a !== ea || sel_b !== eb || sel_st !== es) begin
            n_fail++;
            $display("FAIL %s: got a=%b b=%b st=%b, expected a=%b b=%b st=%b",
                     req, sel_a, sel_b, sel_st, ea, eb, es);
        end
    endtask

    task automatic t_idle();
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        expect3("R1 all zero", 2'b00, 2'b00, 1'b0);
        apply(3, 4, 7, 1, 0, 9, 1, 1, 6, 1);
        expect3("R1 no match", 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_exec_bypass();
        apply(8, 3, 8, 1, 0, 0, 0, 0, 0, 0);
        expect3("R2 operand a after execute", 2'b10, 2'b00, 1'b0);
        apply(31, 31, 31, 1, 0, 0, 0, 0, 0, 0);
        expect3("R2 reg31 both", 2'b10, 2'b10, 1'b0);
    endtask

    task automatic t_wback_bypass();
        apply(2, 9, 0, 0, 0, 9, 1, 1, 0, 0);
        expect3("R3 loaded value to b", 2'b00, 2'b01, 1'b0);
    endtask

    task automatic t_conflict();
        apply(1, 4, 1, 1, 0, 1, 1, 0, 0, 0);
        expect3("R4 younger wins", 2'b10, 2'b00, 1'b0);
        apply(1, 4, 1, 0, 0, 1, 1, 0, 0, 0);
        expect3("R6 younger we low falls to older", 2'b01, 2'b00, 1'b0);
    endtask

    task automatic t_zero_reg();
        apply(0, 0, 0, 1, 0, 0, 1, 1, 0, 1);
        expect3("R5 register zero", 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_we_low();
        apply(6, 6, 6, 0, 0, 6, 0, 1, 6, 1);
        expect3("R6 write enables low", 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_same_reg();
        apply(2, 2, 2, 1, 0, 0, 0, 0, 0, 0);
        expect3("R7 same reg after execute", 2'b10, 2'b10, 1'b0);
        apply(2, 2, 0, 0, 0, 2, 1, 0, 0, 0);
        expect3("R7 same reg before write-back", 2'b01, 2'b01, 1'b0);
    endtask

    task automatic t_mem_copy();
        apply(0, 0, 0, 0, 0, 5, 1, 1, 5, 1);
        expect3("R8 load then store", 2'b00, 2'b00, 1'b1);
        apply(0, 0, 0, 0, 0, 5, 1, 0, 5, 1);
        expect3("R9 non-load producer", 2'b00, 2'b00, 1'b0);
        apply(0, 0, 0, 0, 0, 5, 1, 1, 5, 0);
        expect3("R9 no store present", 2'b00, 2'b00, 1'b0);
    endtask

    task automatic t_load_after_exec();
        apply(7, 7, 7, 1, 1, 0, 0, 0, 0, 0);
        expect3("R10 load after execute not used", 2'b00, 2'b00, 1'b0);
        apply(7, 3, 7, 1, 1, 7, 1, 0, 0, 0);
        expect3("R10 load skipped, older used", 2'b01, 2'b00, 1'b0);
    endtask

    initial begin
        clear_all();
        repeat (2) @(posedge clk);
        t_idle();
        t_exec_bypass();
        t_wback_bypass();
        t_conflict();
        t_zero_reg();
        t_we_low();
        t_same_reg();
        t_mem_copy();
        t_load_after_exec();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule